// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations for a processor's memory pipeline. Every cached translation is tagged with the process identifier that owns it, so a context switch does not need to discard the cache. A lookup presents a process identifier, a virtual page number and a read/write flag. One cycle later the block answers with hit, frame number and permission bits, or with a protection fault when a write reaches a read-only page.

A lookup that misses sends one request to an external page-table walker. The walker later returns one result beat. That beat is one of three outcomes: an invalid-address exception, a page-not-present fault, or a translation. A translation is installed, and the block pulses a retry flag so that the pipeline replays the access. Software-driven controls either empty the whole buffer or remove the single entry that matches a process and page, for example after a permission reduction.

Top module: `ptag_tlb`

## Requirements
- R1: After reset no entry is valid, and `rsp_valid`, `walk_req`, `exc_badaddr`, `fault_absent` and `retry` are all low.
- R2: A lookup hits only when a valid entry matches both `lk_pid` and `lk_vpn`. The answer appears on the cycle after the lookup, with `rsp_valid` high. On a hit, `rsp_pfn` and `rsp_perm` carry the entry's contents (perm bit 0 = read allowed, bit 1 = write allowed). On any non-hit, `rsp_hit`, `rsp_pfn` and `rsp_perm` are zero.
- R3: A miss that occurs while no walk is outstanding raises `walk_req` for one cycle, in the same cycle as its response. That cycle carries the missing process and page on `walk_pid` and `walk_vpn`.
- R4: A walk result with `wr_addr_ok` low pulses `exc_badaddr` on the next cycle and installs nothing.
- R5: A walk result with `wr_addr_ok` high and `wr_present` low pulses `fault_absent` on the next cycle and installs nothing.
- R6: A walk result with both flags high installs the requested translation with `wr_pfn` and `wr_perm`, and pulses `retry` on the next cycle. Lookups issued from that next cycle onward hit.
- R7: `flush` invalidates every entry.
- R8: `purge` invalidates only the entry that matches both `purge_pid` and `purge_vpn`. Other entries keep their contents.
- R9: A write lookup that matches an entry lacking write permission gives `rsp_prot` high and `rsp_hit` low, and raises no walk request.
- R10: While a walk is outstanding, further misses still answer as misses but raise no new walk request.
- R11: A lookup issued in the same cycle as `flush` or `purge` is answered from the contents before that update.
- R12: An install goes to the lowest-numbered invalid entry when one exists.
- R13: When every entry is valid, an install replaces the entry at a rotating pointer. The pointer starts at entry 0 after reset and advances by one (wrapping) after each such replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_pid | input | PID_W | Lookup process identifier |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_write | input | 1 | Lookup is a write access |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_prot | output | 1 | Write to a page without write permission |
| rsp_pfn | output | PFN_W | Physical frame number on hit |
| rsp_perm | output | 2 | Permission bits on hit |
| walk_req | output | 1 | Walk request pulse |
| walk_pid | output | PID_W | Process of the outstanding walk |
| walk_vpn | output | VPN_W | Page of the outstanding walk |
| wr_valid | input | 1 | Walk result beat |
| wr_addr_ok | input | 1 | Walked address is valid |
| wr_present | input | 1 | Page is resident |
| wr_pfn | input | PFN_W | Frame number from the walk |
| wr_perm | input | 2 | Permission bits from the walk |
| exc_badaddr | output | 1 | Invalid-address exception pulse |
| fault_absent | output | 1 | Page-not-present fault pulse |
| retry | output | 1 | Translation installed, replay the access |
| flush | input | 1 | Invalidate all entries |
| purge | input | 1 | Invalidate the matching entry |
| purge_pid | input | PID_W | Process to purge |
| purge_vpn | input | VPN_W | Page to purge |

## Verification
A lookup's answer and any walk request it causes both appear exactly one cycle after the lookup strobe. Outcome flags appear one cycle after the walk result beat, and the installed entry serves lookups from that same following cycle. The bench drives every input on a falling edge and pushes the expected answer into a queue. A monitor pops that queue whenever `rsp_valid` is high at a falling edge, and the driver tasks read the request and outcome flags at the first falling edge after the sampling edge. A lookup made together with a flush or purge is therefore compared against the old contents, and the very next lookup against the new contents.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int PERM_W  = 2;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;

  typedef enum logic [1:0] {
    OUT_NONE    = 2'd0,
    OUT_BADADDR = 2'd1,
    OUT_ABSENT  = 2'd2,
    OUT_INSTALL = 2'd3
  } walk_out_e;

  // Outcome of a walk result beat.
  function automatic walk_out_e classify(input logic beat, input logic ok, input logic present);
    if (!beat)        return OUT_NONE;
    else if (!ok)     return OUT_BADADDR;
    else if (!present) return OUT_ABSENT;
    else              return OUT_INSTALL;
  endfunction

  // A write to a page whose write bit is clear is refused.
  function automatic logic write_denied(input logic [PERM_W-1:0] perm, input logic wr);
    return wr && !perm[PERM_WR];
  endfunction
endpackage

// File: rtl/ptlb_store.sv
module ptlb_store #(
  parameter int N     = 8,
  parameter int PID_W = 4,
  parameter int VPN_W = 12,
  parameter int PFN_W = 10,
  parameter int IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         purge,
  input  logic [PID_W-1:0]             purge_pid,
  input  logic [VPN_W-1:0]             purge_vpn,
  input  logic                         ins_en,
  input  logic [IDX_W-1:0]             ins_idx,
  input  logic [PID_W-1:0]             ins_pid,
  input  logic [VPN_W-1:0]             ins_vpn,
  input  logic [PFN_W-1:0]             ins_pfn,
  input  logic [ptlb_pkg::PERM_W-1:0]  ins_perm,
  input  logic [PID_W-1:0]             q_pid,
  input  logic [VPN_W-1:0]             q_vpn,
  output logic [N-1:0]                 hit_vec,
  output logic [N-1:0]                 valid_vec,
  output logic [PFN_W-1:0]             q_pfn,
  output logic [ptlb_pkg::PERM_W-1:0]  q_perm
);
  localparam int PW = ptlb_pkg::PERM_W;
  logic [N-1:0][PFN_W-1:0] pfn_arr;
  logic [N-1:0][PW-1:0]    perm_arr;

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic             v_q;
    logic [PID_W-1:0] pid_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PFN_W-1:0] pfn_q;
    logic [PW-1:0]    perm_q;
    logic             purge_hit, ins_here;

    assign purge_hit = purge && v_q && (pid_q == purge_pid) && (vpn_q == purge_vpn);
    assign ins_here  = ins_en && (ins_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         v_q <= 1'b0;
      else if (flush)     v_q <= 1'b0;
      else if (ins_here)  v_q <= 1'b1;
      else if (purge_hit) v_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (ins_here) begin
        pid_q  <= ins_pid;
        vpn_q  <= ins_vpn;
        pfn_q  <= ins_pfn;
        perm_q <= ins_perm;
      end
    end

    assign hit_vec[e]   = v_q && (pid_q == q_pid) && (vpn_q == q_vpn);
    assign valid_vec[e] = v_q;
    assign pfn_arr[e]   = pfn_q;
    assign perm_arr[e]  = perm_q;
  end

  always_comb begin
    q_pfn  = '0;
    q_perm = '0;
    for (int i = 0; i < N; i++) begin
      q_pfn  = q_pfn  | ({PFN_W{hit_vec[i]}} & pfn_arr[i]);
      q_perm = q_perm | ({PW{hit_vec[i]}}    & perm_arr[i]);
    end
  end
endmodule

// File: rtl/ptlb_victim.sv
module ptlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic             ins_go,
  output logic [IDX_W-1:0] victim
);
  logic             any_free;
  logic [IDX_W-1:0] free_idx, rr_q;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_vec[i]) free_idx = IDX_W'(i);
  end

  assign any_free = ~&valid_vec;
  assign victim   = any_free ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (ins_go && !any_free)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/ptlb_walkctl.sv
module ptlb_walkctl #(
  parameter int PID_W = 4,
  parameter int VPN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_ev,
  input  logic [PID_W-1:0] lk_pid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             wr_valid,
  input  logic             wr_addr_ok,
  input  logic             wr_present,
  output logic             walk_req,
  output logic [PID_W-1:0] walk_pid,
  output logic [VPN_W-1:0] walk_vpn,
  output logic             pending,
  output logic             ins_req,
  output logic             exc_badaddr,
  output logic             fault_absent,
  output logic             retry
);
  import ptlb_pkg::*;
  walk_out_e outc;
  logic      launch;

  assign outc    = classify(wr_valid && pending, wr_addr_ok, wr_present);
  assign launch  = miss_ev && !pending;
  assign ins_req = (outc == OUT_INSTALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_req     <= 1'b0;
      walk_pid     <= '0;
      walk_vpn     <= '0;
      pending      <= 1'b0;
      exc_badaddr  <= 1'b0;
      fault_absent <= 1'b0;
      retry        <= 1'b0;
    end else begin
      walk_req     <= launch;
      if (launch) begin
        walk_pid <= lk_pid;
        walk_vpn <= lk_vpn;
      end
      if (launch)                pending <= 1'b1;
      else if (outc != OUT_NONE) pending <= 1'b0;
      exc_badaddr  <= (outc == OUT_BADADDR);
      fault_absent <= (outc == OUT_ABSENT);
      retry        <= (outc == OUT_INSTALL);
    end
  end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb #(
  parameter int N     = 8,
  parameter int PID_W = 4,
  parameter int VPN_W = 12,
  parameter int PFN_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_valid,
  input  logic [PID_W-1:0]            lk_pid,
  input  logic [VPN_W-1:0]            lk_vpn,
  input  logic                        lk_write,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic                        rsp_prot,
  output logic [PFN_W-1:0]            rsp_pfn,
  output logic [ptlb_pkg::PERM_W-1:0] rsp_perm,
  output logic                        walk_req,
  output logic [PID_W-1:0]            walk_pid,
  output logic [VPN_W-1:0]            walk_vpn,
  input  logic                        wr_valid,
  input  logic                        wr_addr_ok,
  input  logic                        wr_present,
  input  logic [PFN_W-1:0]            wr_pfn,
  input  logic [ptlb_pkg::PERM_W-1:0] wr_perm,
  output logic                        exc_badaddr,
  output logic                        fault_absent,
  output logic                        retry,
  input  logic                        flush,
  input  logic                        purge,
  input  logic [PID_W-1:0]            purge_pid,
  input  logic [VPN_W-1:0]            purge_vpn
);
  import ptlb_pkg::*;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      hit_vec, valid_vec;
  logic [PFN_W-1:0]  q_pfn;
  logic [PERM_W-1:0] q_perm;
  logic              hit_any, denied, lk_hit_ok, lk_prot_ev, miss_ev;
  logic              ins_req, ins_go, pending;
  logic [IDX_W-1:0]  victim;

  assign hit_any    = |hit_vec;
  assign denied     = write_denied(q_perm, lk_write);
  assign lk_hit_ok  = lk_valid && hit_any && !denied;
  assign lk_prot_ev = lk_valid && hit_any && denied;
  assign miss_ev    = lk_valid && !hit_any;
  assign ins_go     = ins_req && !flush;

  ptlb_store #(.N(N), .PID_W(PID_W), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .purge(purge),
    .purge_pid(purge_pid), .purge_vpn(purge_vpn),
    .ins_en(ins_go), .ins_idx(victim), .ins_pid(walk_pid), .ins_vpn(walk_vpn),
    .ins_pfn(wr_pfn), .ins_perm(wr_perm),
    .q_pid(lk_pid), .q_vpn(lk_vpn),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .q_pfn(q_pfn), .q_perm(q_perm)
  );

  ptlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .ins_go(ins_go), .victim(victim)
  );

  ptlb_walkctl #(.PID_W(PID_W), .VPN_W(VPN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .miss_ev(miss_ev), .lk_pid(lk_pid), .lk_vpn(lk_vpn),
    .wr_valid(wr_valid), .wr_addr_ok(wr_addr_ok), .wr_present(wr_present),
    .walk_req(walk_req), .walk_pid(walk_pid), .walk_vpn(walk_vpn), .pending(pending),
    .ins_req(ins_req), .exc_badaddr(exc_badaddr), .fault_absent(fault_absent), .retry(retry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit_ok;
      rsp_prot  <= lk_prot_ev;
      rsp_pfn   <= lk_hit_ok ? q_pfn : '0;
      rsp_perm  <= lk_hit_ok ? q_perm : '0;
    end
  end
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         purge,
  input logic         wr_valid,
  input logic         wr_addr_ok,
  input logic         wr_present,
  input logic         pending,
  input logic         rsp_valid,
  input logic         rsp_hit,
  input logic         rsp_prot,
  input logic         walk_req,
  input logic         exc_badaddr,
  input logic         fault_absent,
  input logic         retry,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] valid_vec
);
  p_hit_single_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  p_req_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (rsp_valid && !rsp_hit && !rsp_prot));
  p_exc_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_badaddr |-> ($stable(valid_vec) || $past(flush) || $past(purge)));
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_badaddr, fault_absent, retry}));
  p_install_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && pending && wr_addr_ok && wr_present) |=> retry);
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
  p_prot_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot |-> (!rsp_hit && !walk_req));
  p_single_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !$past(pending));
endmodule

bind ptag_tlb ptlb_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .purge(purge),
  .wr_valid(wr_valid), .wr_addr_ok(wr_addr_ok), .wr_present(wr_present),
  .pending(pending), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_prot(rsp_prot),
  .walk_req(walk_req), .exc_badaddr(exc_badaddr), .fault_absent(fault_absent),
  .retry(retry), .hit_vec(hit_vec), .valid_vec(valid_vec)
);

// File: tb/sim_ptag_tlb.sv
`timescale 1ns/1ps
module sim_ptag_tlb;
  localparam int PID_W = 4, VPN_W = 12, PFN_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0;
  logic [PID_W-1:0] lk_pid = '0, purge_pid = '0;
  logic [VPN_W-1:0] lk_vpn = '0, purge_vpn = '0;
  logic wr_valid = 0, wr_addr_ok = 0, wr_present = 0, flush = 0, purge = 0;
  logic [PFN_W-1:0] wr_pfn = '0;
  logic [1:0] wr_perm = '0;
  logic rsp_valid, rsp_hit, rsp_prot, walk_req, exc_badaddr, fault_absent, retry;
  logic [PFN_W-1:0] rsp_pfn;
  logic [1:0] rsp_perm;
  logic [PID_W-1:0] walk_pid;
  logic [VPN_W-1:0] walk_vpn;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string rq_q[$];

  always #10 clk = ~clk;

  ptag_tlb u0 (.*);

  task automatic note(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Scoreboard monitor: compare each answer against the queued expectation.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) note(0, "R2", "unexpected answer", 1, 0);
      else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = rq_q.pop_front();
        note({2'b00, rsp_hit, rsp_prot, rsp_perm, rsp_pfn} == e, r, "answer",
             {2'b00, rsp_hit, rsp_prot, rsp_perm, rsp_pfn}, e);
      end
    end
  end

  // Driver: one lookup cycle; flush/purge set by the caller apply to this cycle.
  task automatic lookup(input int pid, input int vpn, input bit wr, input bit e_hit, input bit e_prot,
                        input int e_pfn, input int e_perm, input bit e_req, input string rq);
    exp_q.push_back({2'b00, e_hit, e_prot, 2'(e_perm), PFN_W'(e_pfn)});
    rq_q.push_back(rq);
    lk_valid = 1; lk_pid = PID_W'(pid); lk_vpn = VPN_W'(vpn); lk_write = wr;
    @(negedge clk);
    lk_valid = 0; lk_write = 0; flush = 0; purge = 0;
    note(walk_req == e_req, rq, "walk_req", walk_req, e_req);
    if (e_req) note({walk_pid, walk_vpn} == {PID_W'(pid), VPN_W'(vpn)}, rq, "walk tag",
                    {walk_pid, walk_vpn}, {PID_W'(pid), VPN_W'(vpn)});
  endtask

  // Walk result beat; code: 1 = exception, 2 = absent, 4 = retry.
  task automatic walk(input bit ok, input bit pres, input int pfn, input int perm, input int e_code, input string rq);
    wr_valid = 1; wr_addr_ok = ok; wr_present = pres; wr_pfn = PFN_W'(pfn); wr_perm = 2'(perm);
    @(negedge clk);
    wr_valid = 0;
    note({retry, fault_absent, exc_badaddr} == 3'(e_code), rq, "outcome",
         {retry, fault_absent, exc_badaddr}, e_code);
  endtask

  task automatic fill(input int pid, input int vpn, input int pfn, input int perm, input string rq);
    lookup(pid, vpn, 0, 0, 0, 0, 0, 1, rq);
    walk(1, 1, pfn, perm, 4, rq);
  endtask

  task automatic miss_chk(input int pid, input int vpn, input string rq);
    lookup(pid, vpn, 0, 0, 0, 0, 0, 1, rq);
    walk(1, 0, 0, 0, 2, rq);
  endtask

  initial begin
    #(20 * 200000);
    note(0, "WATCHDOG", "timeout", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs after reset
    note({rsp_valid, walk_req, exc_badaddr, fault_absent, retry} == 5'b0, "R1", "reset outputs",
         {rsp_valid, walk_req, exc_badaddr, fault_absent, retry}, 0);

    // R1/R3: empty buffer misses and requests a walk; R6: install then hit
    lookup(1, 'h10, 0, 0, 0, 0, 0, 1, "R1");
    walk(1, 1, 'h55, 3, 4, "R6");
    lookup(1, 'h10, 1, 1, 0, 'h55, 3, 0, "R6");
    // R2: same page under another process misses; R4: bad address installs nothing
    lookup(2, 'h10, 0, 0, 0, 0, 0, 1, "R2");
    walk(0, 0, 0, 0, 1, "R4");
    lookup(2, 'h10, 0, 0, 0, 0, 0, 1, "R4");
    walk(1, 0, 0, 0, 2, "R5");
    lookup(2, 'h10, 0, 0, 0, 0, 0, 1, "R5");
    walk(1, 0, 0, 0, 2, "R5");

    // R9: read-only page refuses writes without a walk
    fill(1, 'h20, 'h66, 1, "R6");
    lookup(1, 'h20, 1, 0, 1, 0, 0, 0, "R9");
    lookup(1, 'h20, 0, 1, 0, 'h66, 1, 0, "R9");

    // R10: second miss while a walk is outstanding raises no request
    lookup(3, 1, 0, 0, 0, 0, 0, 1, "R10");
    lookup(3, 2, 0, 0, 0, 0, 0, 0, "R10");
    walk(0, 0, 0, 0, 1, "R10");

    // R11 + R8: purge with a lookup in the same cycle
    purge = 1; purge_pid = 1; purge_vpn = 'h10;
    lookup(1, 'h10, 0, 1, 0, 'h55, 3, 0, "R11");
    miss_chk(1, 'h10, "R8");
    lookup(1, 'h20, 0, 1, 0, 'h66, 1, 0, "R8");

    // R11 + R7: flush with a lookup in the same cycle
    flush = 1;
    lookup(1, 'h20, 0, 1, 0, 'h66, 1, 0, "R11");
    miss_chk(1, 'h20, "R7");

    // R12/R13: fill all entries, then replacement order
    for (int k = 0; k < 8; k++) fill(4, k, 'h100 + k, 3, "R12");
    fill(4, 8, 'h108, 3, "R13");
    fill(4, 9, 'h109, 3, "R13");
    purge = 1; purge_pid = 4; purge_vpn = 5;
    @(negedge clk);
    purge = 0;
    fill(4, 20, 'h120, 3, "R12");
    fill(4, 21, 'h121, 3, "R13");
    miss_chk(4, 0, "R13");
    miss_chk(4, 1, "R13");
    miss_chk(4, 2, "R13");
    lookup(4, 3, 0, 1, 0, 'h103, 3, 0, "R12");
    lookup(4, 20, 0, 1, 0, 'h120, 3, 0, "R12");
    lookup(4, 21, 0, 1, 0, 'h121, 3, 0, "R13");
    lookup(4, 8, 0, 1, 0, 'h108, 3, 0, "R13");
    miss_chk(4, 5, "R8");

    @(negedge clk);
    note(exp_q.size() == 0, "R2", "answers outstanding", exp_q.size(), 0);
    finish_up();
  end
endmodule